// File: doc/BRIEF.md
# Three-Group Power Rail Sequencer

This controller drives the regulator enables of three supply groups for a large programmable device. External comparators report, per rail, whether the rail is above its good threshold (90 % of nominal) and whether it is below its discharged threshold (10 % of nominal). On a power request the block brings up a single core rail first, then the remaining first-group rails, then the second group, then the third. On release it takes them down in exactly the reverse order. Each step advances only when every rail of the group being handled reports the needed threshold.

When the third group shares a regulator with the second, a merge input, captured at the start of each power-up, makes both groups switch together. While any step is in progress the block asks the pad ring to tri-state the device I/O. A ready flag follows one cycle after normal operation begins. A per-step cycle limit and an optional whole-ramp budget for fast configuration detect rails that fail to come up. A fault latches and triggers the reverse shutdown. A power request withdrawn mid-ramp also unwinds from the highest group that is enabled, without a fault.

Top module: `rail_group_sequencer`

## Requirements
- R1: Second-group enables rise only in the cycle after every first-group rail reported its good flag.
- R2: Without merge, third-group enables rise only in the cycle after every second-group rail reported its good flag.
- R3: On shutdown, second-group enables fall only after every third-group rail reports discharged and third-group enables are low. First-group enables fall only after every second-group rail reports discharged.
- R4: The core enable rises first, and first-group enables rise only after the core rail reported good.
- R5: The core enable falls last, only after all first-group enables are low and those rails reported discharged.
- R6: With merge captured at 1 for a sequence, second- and third-group enables are equal in every cycle.
- R7: `io_tristate` is 1 from reset and throughout every sequence. It is 0 only in normal operation, where every enable is 1.
- R8: `ready` rises one cycle after `io_tristate` falls, and is 0 in the cycle `io_tristate` returns to 1.
- R9: If a ramp step does not complete within `step_limit` cycles of entering it, `fault` sets and the reverse shutdown runs. A faulted block does not restart until `pwr_req` has been 0, which clears `fault`.
- R10: With `fast_cfg` = 1, if normal operation is not reached within `FAST_BUDGET` cycles of the core enable rising, `fault` sets and the reverse shutdown runs. With `fast_cfg` = 0 no such limit applies.
- R11: Dropping `pwr_req` during power-up unwinds from the highest enabled group, never enables a higher group, and leaves `fault` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | 1 requests power, 0 requests shutdown |
| merge_23 | input | 1 | Groups 2 and 3 switch together; captured when a power-up starts |
| fast_cfg | input | 1 | Enables the whole-ramp budget check |
| step_limit | input | TW | Cycle limit for each ramp step |
| core_hi | input | 1 | Core rail above good threshold |
| core_lo | input | 1 | Core rail below discharged threshold |
| g1_hi | input | N1 | Other first-group rails above good threshold |
| g1_lo | input | N1 | Other first-group rails discharged |
| g2_hi | input | N2 | Second-group rails good |
| g2_lo | input | N2 | Second-group rails discharged |
| g3_hi | input | N3 | Third-group rails good |
| g3_lo | input | N3 | Third-group rails discharged |
| en_core | output | 1 | Core regulator enable |
| en_g1 | output | N1 | First-group regulator enables |
| en_g2 | output | N2 | Second-group regulator enables |
| en_g3 | output | N3 | Third-group regulator enables |
| io_tristate | output | 1 | Request to tri-state device I/O |
| ready | output | 1 | All rails up, I/O released |
| fault | output | 1 | Latched ramp fault |

## Verification
Every enable is decoded from one state register. A wrong state therefore shows at the ports in the same cycle, as an enable pattern that breaks group order or as an I/O release with a rail off. The bench checks each enable edge against the threshold flags its rail model produced in the cycle before. A timer that counts wrongly shows up as a fault that is missing or comes too early, within one step of the limit. An unwind that starts from the wrong point shows up as a group that rises after the request was withdrawn.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_UP_CORE, S_UP_G1, S_UP_G2, S_UP_G3,
    S_ON, S_DN_G3, S_DN_G2, S_DN_G1, S_DN_CORE
  } seq_state_e;

  function automatic logic is_ramp_up(seq_state_e s);
    return (s == S_UP_CORE) || (s == S_UP_G1) || (s == S_UP_G2) || (s == S_UP_G3);
  endfunction

  // Next step once the current group reports good.
  function automatic seq_state_e up_successor(seq_state_e s, logic merged);
    seq_state_e r;
    case (s)
      S_UP_CORE: r = S_UP_G1;
      S_UP_G1:   r = S_UP_G2;
      S_UP_G2:   r = merged ? S_ON : S_UP_G3;
      default:   r = S_ON;
    endcase
    return r;
  endfunction

  // Shutdown entry point from a ramp step: highest enabled group first.
  function automatic seq_state_e retreat_from(seq_state_e s, logic merged);
    seq_state_e r;
    case (s)
      S_UP_CORE: r = S_DN_CORE;
      S_UP_G1:   r = S_DN_G1;
      S_UP_G2:   r = merged ? S_DN_G3 : S_DN_G2;
      default:   r = S_DN_G3;
    endcase
    return r;
  endfunction

  function automatic seq_state_e down_successor(seq_state_e s, logic merged);
    seq_state_e r;
    case (s)
      S_DN_G3: r = merged ? S_DN_G1 : S_DN_G2;
      S_DN_G2: r = S_DN_G1;
      S_DN_G1: r = S_DN_CORE;
      default: r = S_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rgs_ramp_timer.sv
module rgs_ramp_timer #(
  parameter int TW          = 8,
  parameter int FAST_BUDGET = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          up_phase,
  input  logic          fast_en,
  input  logic [TW-1:0] limit,
  output logic          step_expired,
  output logic          budget_expired
);
  localparam int BW = $clog2(FAST_BUDGET + 1);
  localparam logic [TW-1:0] STEP_MAX = {TW{1'b1}};
  localparam logic [BW-1:0] TOT_MAX  = {BW{1'b1}};

  logic [TW-1:0] step_cnt;
  logic [BW-1:0] tot_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
    end else if (restart) begin
      step_cnt <= '0;
    end else if (up_phase && step_cnt != STEP_MAX) begin
      step_cnt <= step_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_cnt <= '0;
    end else if (!up_phase) begin
      tot_cnt <= '0;
    end else if (tot_cnt != TOT_MAX) begin
      tot_cnt <= tot_cnt + 1'b1;
    end
  end

  assign step_expired   = up_phase && (step_cnt >= limit);
  assign budget_expired = fast_en && up_phase && (tot_cnt >= BW'(FAST_BUDGET));
endmodule

// File: rtl/rgs_rail_decode.sv
module rgs_rail_decode
  import rgs_pkg::*;
#(
  parameter int N1 = 3,
  parameter int N2 = 2,
  parameter int N3 = 2
) (
  input  seq_state_e    state,
  input  logic          merge_q,
  input  logic          core_hi,
  input  logic          core_lo,
  input  logic [N1-1:0] g1_hi,
  input  logic [N1-1:0] g1_lo,
  input  logic [N2-1:0] g2_hi,
  input  logic [N2-1:0] g2_lo,
  input  logic [N3-1:0] g3_hi,
  input  logic [N3-1:0] g3_lo,
  output logic          en_core,
  output logic [N1-1:0] en_g1,
  output logic [N2-1:0] en_g2,
  output logic [N3-1:0] en_g3,
  output logic          up_good,
  output logic          down_clear
);
  logic g1_on, g2_on, g3_on;

  assign en_core = (state != S_OFF) && (state != S_DN_CORE);
  assign g1_on   = (state == S_UP_G1) || (state == S_UP_G2) || (state == S_UP_G3) ||
                   (state == S_ON) || (state == S_DN_G3) || (state == S_DN_G2);
  assign g2_on   = (state == S_UP_G2) || (state == S_UP_G3) || (state == S_ON) ||
                   ((state == S_DN_G3) && !merge_q);
  assign g3_on   = (state == S_UP_G3) || (state == S_ON) ||
                   ((state == S_UP_G2) && merge_q);

  for (genvar i = 0; i < N1; i++) begin : g_en1
    assign en_g1[i] = g1_on;
  end
  for (genvar i = 0; i < N2; i++) begin : g_en2
    assign en_g2[i] = g2_on;
  end
  for (genvar i = 0; i < N3; i++) begin : g_en3
    assign en_g3[i] = g3_on;
  end

  always_comb begin
    case (state)
      S_UP_CORE: up_good = core_hi;
      S_UP_G1:   up_good = &g1_hi;
      S_UP_G2:   up_good = (&g2_hi) && (!merge_q || (&g3_hi));
      S_UP_G3:   up_good = &g3_hi;
      default:   up_good = 1'b0;
    endcase
    case (state)
      S_DN_G3:   down_clear = (&g3_lo) && (!merge_q || (&g2_lo));
      S_DN_G2:   down_clear = &g2_lo;
      S_DN_G1:   down_clear = &g1_lo;
      S_DN_CORE: down_clear = core_lo;
      default:   down_clear = 1'b0;
    endcase
  end
endmodule

// File: rtl/rgs_seq_fsm.sv
module rgs_seq_fsm
  import rgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_req,
  input  logic       merge_23,
  input  logic       up_good,
  input  logic       down_clear,
  input  logic       step_expired,
  input  logic       budget_expired,
  output seq_state_e state,
  output logic       merge_q,
  output logic       fault_q,
  output logic       ready_q,
  output logic       state_chg,
  output logic       up_phase,
  output logic       timeout_evt,
  output logic       abort_evt
);
  seq_state_e nxt;

  always_comb begin
    nxt         = state;
    timeout_evt = 1'b0;
    abort_evt   = 1'b0;
    if (state == S_OFF) begin
      if (pwr_req && !fault_q) nxt = S_UP_CORE;
    end else if (is_ramp_up(state)) begin
      if (!pwr_req) begin
        nxt       = retreat_from(state, merge_q);
        abort_evt = 1'b1;
      end else if (up_good) begin
        nxt = up_successor(state, merge_q);
      end else if (step_expired || budget_expired) begin
        nxt         = retreat_from(state, merge_q);
        timeout_evt = 1'b1;
      end
    end else if (state == S_ON) begin
      if (!pwr_req) nxt = S_DN_G3;
    end else begin
      if (down_clear) nxt = down_successor(state, merge_q);
    end
  end

  assign state_chg = (nxt != state);
  assign up_phase  = is_ramp_up(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_OFF;
      merge_q <= 1'b0;
      fault_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state   <= nxt;
      ready_q <= (state == S_ON);
      if (state == S_OFF) merge_q <= merge_23;
      if (timeout_evt) fault_q <= 1'b1;
      else if (state == S_OFF && !pwr_req) fault_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rail_group_sequencer.sv
module rail_group_sequencer
  import rgs_pkg::*;
#(
  parameter int N1          = 3,
  parameter int N2          = 2,
  parameter int N3          = 2,
  parameter int TW          = 8,
  parameter int FAST_BUDGET = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_req,
  input  logic          merge_23,
  input  logic          fast_cfg,
  input  logic [TW-1:0] step_limit,
  input  logic          core_hi,
  input  logic          core_lo,
  input  logic [N1-1:0] g1_hi,
  input  logic [N1-1:0] g1_lo,
  input  logic [N2-1:0] g2_hi,
  input  logic [N2-1:0] g2_lo,
  input  logic [N3-1:0] g3_hi,
  input  logic [N3-1:0] g3_lo,
  output logic          en_core,
  output logic [N1-1:0] en_g1,
  output logic [N2-1:0] en_g2,
  output logic [N3-1:0] en_g3,
  output logic          io_tristate,
  output logic          ready,
  output logic          fault
);
  seq_state_e state;
  logic merge_q, fault_q, ready_q, state_chg, up_phase;
  logic up_good, down_clear, step_expired, budget_expired;
  logic timeout_evt, abort_evt;

  rgs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .merge_23(merge_23),
    .up_good(up_good), .down_clear(down_clear),
    .step_expired(step_expired), .budget_expired(budget_expired),
    .state(state), .merge_q(merge_q), .fault_q(fault_q), .ready_q(ready_q),
    .state_chg(state_chg), .up_phase(up_phase),
    .timeout_evt(timeout_evt), .abort_evt(abort_evt)
  );

  rgs_ramp_timer #(.TW(TW), .FAST_BUDGET(FAST_BUDGET)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(state_chg), .up_phase(up_phase),
    .fast_en(fast_cfg), .limit(step_limit),
    .step_expired(step_expired), .budget_expired(budget_expired)
  );

  rgs_rail_decode #(.N1(N1), .N2(N2), .N3(N3)) u_decode (
    .state(state), .merge_q(merge_q),
    .core_hi(core_hi), .core_lo(core_lo),
    .g1_hi(g1_hi), .g1_lo(g1_lo), .g2_hi(g2_hi), .g2_lo(g2_lo),
    .g3_hi(g3_hi), .g3_lo(g3_lo),
    .en_core(en_core), .en_g1(en_g1), .en_g2(en_g2), .en_g3(en_g3),
    .up_good(up_good), .down_clear(down_clear)
  );

  assign io_tristate = (state != S_ON);
  assign ready       = ready_q && (state == S_ON);
  assign fault       = fault_q;
endmodule

// File: rtl/rail_group_sequencer_chk.sv
module rail_group_sequencer_chk #(
  parameter int N1 = 3,
  parameter int N2 = 2,
  parameter int N3 = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_core,
  input logic [N1-1:0] en_g1,
  input logic [N2-1:0] en_g2,
  input logic [N3-1:0] en_g3,
  input logic          core_hi,
  input logic [N1-1:0] g1_hi,
  input logic [N1-1:0] g1_lo,
  input logic [N2-1:0] g2_hi,
  input logic [N2-1:0] g2_lo,
  input logic [N3-1:0] g3_lo,
  input logic          io_tristate,
  input logic          ready,
  input logic          fault,
  input logic          merge_q,
  input logic          timeout_evt,
  input logic          abort_evt
);
  assert_g2_after_g1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_g2[0]) |-> $past(&g1_hi));

  assert_g3_after_g2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_g3[0]) && !merge_q) |-> $past(&g2_hi));

  assert_g2_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_g2[0]) && !merge_q) |-> ($past(&g3_lo) && !en_g3[0]));

  assert_g1_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_g1[0]) |-> $past(&g2_lo));

  assert_core_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_g1[0]) |-> ($past(core_hi) && en_core));

  assert_core_trails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_core) |-> ($past(&g1_lo) && !$past(en_g1[0])));

  assert_merged_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    merge_q |-> (en_g2[0] == en_g3[0]));

  assert_io_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_tristate |-> (en_core && (&en_g1) && (&en_g2) && (&en_g3)));

  assert_ready_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!io_tristate && $past(!io_tristate)));

  assert_fault_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> fault);

  assert_abort_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !fault);
endmodule

bind rail_group_sequencer rail_group_sequencer_chk #(.N1(N1), .N2(N2), .N3(N3)) u_chk (.*);

// File: tb/rail_group_sequencer_bench.sv
module rail_group_sequencer_bench;
  localparam int N1 = 3, N2 = 2, N3 = 2;
  localparam int NR = 1 + N1 + N2 + N3;
  localparam int TW = 8, BUDGET = 40;
  localparam int G1L = 1, G1H = N1, G2L = N1 + 1, G2H = N1 + N2, G3L = N1 + N2 + 1, G3H = NR - 1;

  logic clk = 1'b0, rst_n = 1'b0, pwr_req = 1'b0, merge_23 = 1'b0, fast_cfg = 1'b0;
  logic [TW-1:0] step_limit = 8'd30;
  logic [NR-1:0] hi_vec, lo_vec, en_vec;
  logic en_core, io_tristate, ready, fault;
  logic [N1-1:0] en_g1;
  logic [N2-1:0] en_g2;
  logic [N3-1:0] en_g3;

  int lvl [NR];
  int rate [NR];
  bit stuck [NR];
  logic [NR-1:0] pen;
  bit g1_seen, g3_seen;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign en_vec = {en_g3, en_g2, en_g1, en_core};

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      hi_vec[i] = (lvl[i] >= 14);
      lo_vec[i] = (lvl[i] <= 1);
    end
  end

  rail_group_sequencer #(.N1(N1), .N2(N2), .N3(N3), .TW(TW), .FAST_BUDGET(BUDGET))
  u_rail_group_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .merge_23(merge_23),
    .fast_cfg(fast_cfg), .step_limit(step_limit),
    .core_hi(hi_vec[0]), .core_lo(lo_vec[0]),
    .g1_hi(hi_vec[G1H:G1L]), .g1_lo(lo_vec[G1H:G1L]),
    .g2_hi(hi_vec[G2H:G2L]), .g2_lo(lo_vec[G2H:G2L]),
    .g3_hi(hi_vec[G3H:G3L]), .g3_lo(lo_vec[G3H:G3L]),
    .en_core(en_core), .en_g1(en_g1), .en_g2(en_g2), .en_g3(en_g3),
    .io_tristate(io_tristate), .ready(ready), .fault(fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // All bits of v in [lo_i, hi_i] set.
  function automatic bit all_in(logic [NR-1:0] v, int lo_i, int hi_i);
    bit r = 1'b1;
    for (int i = lo_i; i <= hi_i; i++) r &= v[i];
    return r;
  endfunction

  function automatic bit any_in(logic [NR-1:0] v, int lo_i, int hi_i);
    bit r = 1'b0;
    for (int i = lo_i; i <= hi_i; i++) r |= v[i];
    return r;
  endfunction

  // Rail model and edge-ordering monitor; flags seen now are those the DUT sampled.
  always @(negedge clk) begin
    if (rst_n) begin
      if (any_in(en_vec, G1L, G1H)) g1_seen = 1'b1;
      if (any_in(en_vec, G3L, G3H)) g3_seen = 1'b1;
      if (any_in(en_vec, G1L, G1H) && !any_in(pen, G1L, G1H))
        check(hi_vec[0] && en_vec[0], "R4", int'(hi_vec[0]), 1);
      if (any_in(en_vec, G2L, G2H) && !any_in(pen, G2L, G2H))
        check(all_in(hi_vec, G1L, G1H), "R1", int'(hi_vec[G1H:G1L]), (1 << N1) - 1);
      if (any_in(en_vec, G3L, G3H) && !any_in(pen, G3L, G3H) && !merge_23)
        check(all_in(hi_vec, G2L, G2H), "R2", int'(hi_vec[G2H:G2L]), (1 << N2) - 1);
      if (!any_in(en_vec, G2L, G2H) && any_in(pen, G2L, G2H) && !merge_23)
        check(all_in(lo_vec, G3L, G3H) && !any_in(en_vec, G3L, G3H), "R3",
              int'(lo_vec[G3H:G3L]), (1 << N3) - 1);
      if (!any_in(en_vec, G1L, G1H) && any_in(pen, G1L, G1H))
        check(all_in(lo_vec, G2L, G2H), "R3", int'(lo_vec[G2H:G2L]), (1 << N2) - 1);
      if (!en_vec[0] && pen[0])
        check(all_in(lo_vec, G1L, G1H) && !any_in(en_vec, G1L, G1H), "R5",
              int'(lo_vec[G1H:G1L]), (1 << N1) - 1);
      if (merge_23 && (en_vec[G2L] != pen[G2L] || en_vec[G3L] != pen[G3L]))
        check(en_vec[G2L] == en_vec[G3L], "R6", int'(en_vec[G3L]), int'(en_vec[G2L]));
      if (!io_tristate)
        if (!(&en_vec)) check(1'b0, "R7", int'(en_vec), (1 << NR) - 1);
    end
    for (int i = 0; i < NR; i++) begin
      if (stuck[i]) lvl[i] = 0;
      else if (en_vec[i]) lvl[i] = (lvl[i] + rate[i] > 15) ? 15 : lvl[i] + rate[i];
      else lvl[i] = (lvl[i] - rate[i] < 0) ? 0 : lvl[i] - rate[i];
    end
    pen = en_vec;
  end

  task automatic drive_req(input bit v);
    @(posedge clk); #1 pwr_req = v;
  endtask

  task automatic set_rates(input int r);
    for (int i = 0; i < NR; i++) rate[i] = (r == 0) ? 1 + int'($urandom % 3) : r;
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (io_tristate && k < 400) begin @(negedge clk); k++; end
    check(!io_tristate, req, int'(io_tristate), 0);
    check(!ready, "R8", int'(ready), 0);
    @(negedge clk);
    check(ready && !fault, "R8", int'(ready), 1);
    check(&en_vec, "R7", int'(en_vec), (1 << NR) - 1);
  endtask

  task automatic wait_off(input string req);
    int k = 0;
    while (!(en_vec == '0 && (&lo_vec)) && k < 400) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    check(en_vec == '0 && io_tristate, req, int'(en_vec), 0);
  endtask

  task automatic power_down(input string req);
    drive_req(1'b0);
    @(negedge clk); @(negedge clk);
    check(!ready && io_tristate, "R8", int'(ready), 0);
    wait_off(req);
  endtask

  task automatic wait_fault(input string req);
    int k = 0;
    while (!fault && k < 400) begin @(negedge clk); k++; end
    check(fault, req, int'(fault), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_unused;
    seed_unused = int'($urandom(32'd20240611));
    set_rates(2);
    repeat (4) @(negedge clk);
    check(en_vec == '0, "R7", int'(en_vec), 0);
    check(io_tristate && !ready && !fault, "R7", int'(io_tristate), 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // Plain sequence, unmerged.
    drive_req(1'b1);
    wait_ready("R1");
    power_down("R3");

    // Merged groups 2 and 3.
    @(posedge clk); #1 merge_23 = 1'b1;
    drive_req(1'b1);
    wait_ready("R6");
    power_down("R6");
    @(posedge clk); #1 merge_23 = 1'b0;

    // Abort while group 2 ramps: group 3 never enabled.
    set_rates(1);
    @(posedge clk); #1 g3_seen = 1'b0;
    drive_req(1'b1);
    for (int k = 0; k < 200 && !en_g2[0]; k++) @(negedge clk);
    drive_req(1'b0);
    wait_off("R11");
    check(!g3_seen, "R11", int'(g3_seen), 0);
    check(!fault, "R11", int'(fault), 0);

    // Abort during core ramp: group 1 never enabled.
    @(posedge clk); #1 g1_seen = 1'b0;
    drive_req(1'b1);
    for (int k = 0; k < 50 && !en_core; k++) @(negedge clk);
    drive_req(1'b0);
    wait_off("R11");
    check(!g1_seen && !fault, "R11", int'(g1_seen), 0);

    // Stuck second-group rail: step timeout.
    set_rates(2);
    @(posedge clk); #1 begin stuck[G2L] = 1'b1; step_limit = 8'd20; g3_seen = 1'b0; end
    drive_req(1'b1);
    wait_fault("R9");
    wait_off("R9");
    check(!g3_seen, "R9", int'(g3_seen), 0);
    repeat (20) @(negedge clk);
    check(en_vec == '0 && fault, "R9", int'(en_vec), 0);
    drive_req(1'b0);
    @(negedge clk); @(negedge clk);
    check(!fault, "R9", int'(fault), 0);
    @(posedge clk); #1 begin stuck[G2L] = 1'b0; step_limit = 8'd30; end

    // Whole-ramp budget: slow rails fault only when the budget is on.
    set_rates(1);
    @(posedge clk); #1 fast_cfg = 1'b1;
    drive_req(1'b1);
    wait_fault("R10");
    wait_off("R10");
    check(!ready, "R10", int'(ready), 0);
    drive_req(1'b0);
    repeat (3) @(negedge clk);
    set_rates(3);
    drive_req(1'b1);
    wait_ready("R10");
    power_down("R10");
    set_rates(1);
    @(posedge clk); #1 fast_cfg = 1'b0;
    drive_req(1'b1);
    wait_ready("R10");
    check(!fault, "R10", int'(fault), 0);
    power_down("R10");

    // Random sequences with random merge, ramp speeds and abort points.
    for (int it = 0; it < 24; it++) begin
      int abort_at;
      abort_at = ($urandom % 3 == 0) ? int'($urandom % 40) : -1;
      set_rates(0);
      @(posedge clk); #1 merge_23 = $urandom % 2;
      drive_req(1'b1);
      if (abort_at >= 0) begin
        repeat (abort_at) @(negedge clk);
        drive_req(1'b0);
        wait_off("R11");
        check(!fault, "R11", int'(fault), 0);
      end else begin
        wait_ready("R2");
        power_down("R3");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule